// File: doc/BRIEF.md
# Serial Configuration Loader for a Dual-Channel Frequency Synthesizer

This block receives configuration words over a three-wire serial link (a serial clock, a serial data line and a load strobe). It places them in four configuration latches that set the dividers and modes of a two-channel frequency synthesizer. The two channels are called narrow and wide. Each channel has a reference-path latch, which holds the reference divide ratio and the phase detector and charge pump options. Each channel also has a feedback-path latch, which holds the swallow count, the main count, the prescaler modulus choice and a powerdown request. The decoded fields are presented as registered parallel outputs to the counters and analog controls that use them.

A word is 22 bits long and is sent most significant bit first, one bit per rising edge of the serial clock. The last two bits are the steering code. The 20 bits before them are the payload. A rising edge on the load strobe copies the payload into the latch that the steering code selects. All three serial lines are oversampled and synchronized in the system clock domain. One load strobe therefore produces exactly one latch update, and the serial clock needs to be well below half the system clock rate (a 10 MHz serial clock against a system clock of 50 MHz or more).

A divide ratio below the legal minimum of 3 is still stored as written. Such a write also raises a sticky error flag that stays set until reset.

Top module: `synth_prog_loader`

## Requirements
- R1: After a synchronous reset, every configuration output and the error flag are zero. This means negative detector polarity, low pump current, pump enabled, the smaller prescaler modulus and powered up.
- R2: A serial bit is captured on each rising edge of the serial clock. The word is sent most significant bit first. The last bit sent is the type bit C1. The bit before it is the channel bit C2. The 20 bits before those are payload bits 20 down to 1, in that order.
- R3: C1=0 selects a reference latch and C1=1 a feedback latch. C2=0 selects the narrow channel (index 0) and C2=1 the wide channel (index 1). Only the selected latch changes; the other three hold their values.
- R4: In a reference latch, payload bits 1-15 are the ratio (bit 1 is the LSB), bit 16 is the detector polarity, bit 17 is the high pump current, bit 18 is the pump high-impedance force, bit 19 is the lock-indicator select and bit 20 is the test-output select.
- R5: In a feedback latch, payload bits 1-7 are the swallow count (bit 1 is the LSB), bits 8-18 are the main count (bit 8 is the LSB), bit 19 is the large-modulus select and bit 20 is the powerdown request.
- R6: On the narrow channel, only swallow bits 1-4 take effect. Swallow output bits 5-7 of channel 0 always read zero.
- R7: A reference ratio or main count below 3 is stored unchanged and sets `ratio_err`. The flag stays set through later legal writes and is cleared only by reset. A value of exactly 3 does not set it.
- R8: Latches change only on a rising edge of the load strobe. Shifting with the strobe low or held high changes no output, and one strobe pulse updates at most one latch.
- R9: When more than 22 bits are shifted before a load, only the last 22 bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous |
| ref_ratio | output | 2x15 | Reference divide ratio per channel |
| pd_pos | output | 2 | Phase detector positive polarity |
| cp_hi | output | 2 | High charge pump current |
| cp_hiz | output | 2 | Force charge pump to high impedance |
| lock_sel | output | 2 | Lock indicator select |
| tout_sel | output | 2 | Test output select |
| swallow | output | 2x7 | Swallow count per channel |
| main_cnt | output | 2x11 | Main count per channel |
| mod_hi | output | 2 | Large prescaler modulus select |
| pwr_dn | output | 2 | Powerdown request |
| ratio_err | output | 1 | Sticky illegal-ratio flag |

## Verification
A fault in the shift register or in the field layout shows up as a wrong field value. That value appears a fixed handful of system cycles after the load strobe rises, because of the synchronizer, the edge detector and the latch register. A fault in the steering decode shows up as a change in a latch that was not addressed, or as no change in the addressed one. Both are visible at the same cycle. A broken strobe edge detector shows up as latches that follow the shift register while the strobe is held high. A fault in the error logic shows up at the load cycle as a flag that stays clear or that falls back to zero.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int CTRL_W      = 2;
  localparam int DATA_W      = 20;
  localparam int WORD_W      = DATA_W + CTRL_W;
  localparam int REF_RATIO_W = 15;
  localparam int SWAL_W      = 7;
  localparam int MAIN_W      = 11;
  localparam int N_CHAN      = 2;

  // payload bit k (1-based) lives at vector bit k-1
  typedef struct packed {
    logic                   tout_sel;
    logic                   lock_sel;
    logic                   cp_hiz;
    logic                   cp_hi;
    logic                   pd_pos;
    logic [REF_RATIO_W-1:0] ratio;
  } ref_word_t;

  typedef struct packed {
    logic              pwr_dn;
    logic              mod_hi;
    logic [MAIN_W-1:0] main_cnt;
    logic [SWAL_W-1:0] swallow;
  } fb_word_t;
endpackage

// File: rtl/spl_sync.sv
module spl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spl_shift.sv
module spl_shift #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)     word <= '0;
    else if (en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/spl_chan.sv
module spl_chan
  import synth_prog_pkg::*;
#(
  parameter int SWAL_USE = SWAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ref,
  input  logic              wr_fb,
  input  logic [DATA_W-1:0] din,
  output ref_word_t         ref_o,
  output fb_word_t          fb_o
);
  localparam logic [SWAL_W-1:0] SWAL_MASK = SWAL_W'((1 << SWAL_USE) - 1);

  fb_word_t fb_in;
  fb_word_t fb_masked;

  always_comb begin
    fb_in             = fb_word_t'(din);
    fb_masked         = fb_in;
    fb_masked.swallow = fb_in.swallow & SWAL_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_o <= '0;
      fb_o  <= '0;
    end else begin
      if (wr_ref) ref_o <= ref_word_t'(din);
      if (wr_fb)  fb_o  <= fb_masked;
    end
  end
endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_RATIO    = 3,
  parameter int NARROW_SWAL  = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                ser_clk,
  input  logic                                ser_dat,
  input  logic                                ser_le,
  output logic [N_CHAN-1:0][REF_RATIO_W-1:0]  ref_ratio,
  output logic [N_CHAN-1:0]                   pd_pos,
  output logic [N_CHAN-1:0]                   cp_hi,
  output logic [N_CHAN-1:0]                   cp_hiz,
  output logic [N_CHAN-1:0]                   lock_sel,
  output logic [N_CHAN-1:0]                   tout_sel,
  output logic [N_CHAN-1:0][SWAL_W-1:0]       swallow,
  output logic [N_CHAN-1:0][MAIN_W-1:0]       main_cnt,
  output logic [N_CHAN-1:0]                   mod_hi,
  output logic [N_CHAN-1:0]                   pwr_dn,
  output logic                                ratio_err
);
  logic [2:0] lvl;
  logic       clk_d, le_d;
  logic       sclk_rise, ld_rise;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] payload;
  logic       sel_fb, sel_chan;
  logic       bad_wr;
  logic       err_q;
  ref_word_t  ref_in;
  fb_word_t   fb_in;
  ref_word_t  ref_q [N_CHAN];
  fb_word_t   fb_q  [N_CHAN];

  spl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({ser_le, ser_dat, ser_clk}),
    .q(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d <= 1'b0;
      le_d  <= 1'b0;
    end else begin
      clk_d <= lvl[0];
      le_d  <= lvl[2];
    end
  end

  assign sclk_rise = lvl[0] & ~clk_d;
  assign ld_rise   = lvl[2] & ~le_d;

  spl_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .en(sclk_rise), .din(lvl[1]), .word(word)
  );

  // last bit shifted = type bit, the one before = channel bit
  assign sel_fb   = word[0];
  assign sel_chan = word[1];
  assign payload  = word[WORD_W-1:CTRL_W];
  assign ref_in   = ref_word_t'(payload);
  assign fb_in    = fb_word_t'(payload);

  assign bad_wr = ld_rise &
                  ((!sel_fb && (ref_in.ratio < REF_RATIO_W'(MIN_RATIO))) ||
                   ( sel_fb && (fb_in.main_cnt < MAIN_W'(MIN_RATIO))));

  always_ff @(posedge clk) begin
    if (rst)         err_q <= 1'b0;
    else if (bad_wr) err_q <= 1'b1;
  end

  assign ratio_err = err_q;

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    localparam int USE_W = (g == 0) ? NARROW_SWAL : SWAL_W;
    logic hit;
    assign hit = ld_rise && (sel_chan == g[0]);

    spl_chan #(.SWAL_USE(USE_W)) u_chan (
      .clk(clk), .rst(rst),
      .wr_ref(hit && !sel_fb),
      .wr_fb (hit &&  sel_fb),
      .din(payload),
      .ref_o(ref_q[g]),
      .fb_o(fb_q[g])
    );

    assign ref_ratio[g] = ref_q[g].ratio;
    assign pd_pos[g]    = ref_q[g].pd_pos;
    assign cp_hi[g]     = ref_q[g].cp_hi;
    assign cp_hiz[g]    = ref_q[g].cp_hiz;
    assign lock_sel[g]  = ref_q[g].lock_sel;
    assign tout_sel[g]  = ref_q[g].tout_sel;
    assign swallow[g]   = fb_q[g].swallow;
    assign main_cnt[g]  = fb_q[g].main_cnt;
    assign mod_hi[g]    = fb_q[g].mod_hi;
    assign pwr_dn[g]    = fb_q[g].pwr_dn;
  end
endmodule

// File: rtl/spl_chk.sv
module spl_chk
  import synth_prog_pkg::*;
#(
  parameter int MIN_RATIO = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_pulse,
  input logic [DATA_W-1:0] ref_n,
  input logic [DATA_W-1:0] ref_w,
  input logic [DATA_W-1:0] fb_n,
  input logic [DATA_W-1:0] fb_w,
  input logic              ratio_err
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ref_n == '0 && ref_w == '0 && fb_n == '0 && fb_w == '0 && !ratio_err));

  assert_hold_without_load_R8: assert property (@(posedge clk) disable iff (rst)
    !ld_pulse |=> ($stable(ref_n) && $stable(ref_w) && $stable(fb_n) && $stable(fb_w)));

  assert_single_latch_R3: assert property (@(posedge clk) disable iff (rst)
    ld_pulse |=> ($countones({!$stable(ref_n), !$stable(ref_w),
                              !$stable(fb_n),  !$stable(fb_w)}) <= 1));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ratio_err |=> ratio_err);

  assert_err_on_bad_ratio_R7: assert property (@(posedge clk) disable iff (rst)
    ((!$stable(ref_n) && ref_n[REF_RATIO_W-1:0] < REF_RATIO_W'(MIN_RATIO)) ||
     (!$stable(ref_w) && ref_w[REF_RATIO_W-1:0] < REF_RATIO_W'(MIN_RATIO)) ||
     (!$stable(fb_n)  && fb_n[SWAL_W+MAIN_W-1:SWAL_W] < MAIN_W'(MIN_RATIO)) ||
     (!$stable(fb_w)  && fb_w[SWAL_W+MAIN_W-1:SWAL_W] < MAIN_W'(MIN_RATIO)))
    |-> ratio_err);
endmodule

bind synth_prog_loader spl_chk #(.MIN_RATIO(MIN_RATIO)) u_chk (
  .clk(clk), .rst(rst), .ld_pulse(ld_rise),
  .ref_n(ref_q[0]), .ref_w(ref_q[1]),
  .fb_n(fb_q[0]),   .fb_w(fb_q[1]),
  .ratio_err(ratio_err)
);

// File: tb/tb_synth_prog_loader.sv
`timescale 1ns/1ps
module tb_synth_prog_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [1:0][14:0] ref_ratio;
  logic [1:0] pd_pos, cp_hi, cp_hiz, lock_sel, tout_sel, mod_hi, pwr_dn;
  logic [1:0][6:0]  swallow;
  logic [1:0][10:0] main_cnt;
  logic ratio_err;

  always #2.5 clk = ~clk;

  synth_prog_loader dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .ref_ratio(ref_ratio), .pd_pos(pd_pos), .cp_hi(cp_hi), .cp_hiz(cp_hiz),
    .lock_sel(lock_sel), .tout_sel(tout_sel), .swallow(swallow),
    .main_cnt(main_cnt), .mod_hi(mod_hi), .pwr_dn(pwr_dn), .ratio_err(ratio_err)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  // reference model
  int e_ratio[2], e_pol[2], e_cur[2], e_hiz[2], e_ld[2], e_fo[2];
  int e_swal[2], e_main[2], e_mod[2], e_pd[2];
  int e_err;

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      e_ratio[c] = 0; e_pol[c] = 0; e_cur[c] = 0; e_hiz[c] = 0; e_ld[c] = 0;
      e_fo[c] = 0; e_swal[c] = 0; e_main[c] = 0; e_mod[c] = 0; e_pd[c] = 0;
    end
    e_err = 0;
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < 2; c++) begin
      chk(tag, $sformatf("ref_ratio[%0d]", c), int'(ref_ratio[c]), e_ratio[c]);
      chk(tag, $sformatf("pd_pos[%0d]", c),    int'(pd_pos[c]),    e_pol[c]);
      chk(tag, $sformatf("cp_hi[%0d]", c),     int'(cp_hi[c]),     e_cur[c]);
      chk(tag, $sformatf("cp_hiz[%0d]", c),    int'(cp_hiz[c]),    e_hiz[c]);
      chk(tag, $sformatf("lock_sel[%0d]", c),  int'(lock_sel[c]),  e_ld[c]);
      chk(tag, $sformatf("tout_sel[%0d]", c),  int'(tout_sel[c]),  e_fo[c]);
      chk(tag, $sformatf("swallow[%0d]", c),   int'(swallow[c]),   e_swal[c]);
      chk(tag, $sformatf("main_cnt[%0d]", c),  int'(main_cnt[c]),  e_main[c]);
      chk(tag, $sformatf("mod_hi[%0d]", c),    int'(mod_hi[c]),    e_mod[c]);
      chk(tag, $sformatf("pwr_dn[%0d]", c),    int'(pwr_dn[c]),    e_pd[c]);
    end
    chk(tag, "ratio_err", int'(ratio_err), e_err);
  endtask

  task automatic do_reset();
    rst = 1'b1; ser_clk = 0; ser_dat = 0; ser_le = 0;
    wait_clks(4);
    rst = 1'b0;
    wait_clks(2);
    model_clear();
  endtask

  // shift n bits of v, MSB first
  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      wait_clks(3);
      ser_clk = 1'b1;
      wait_clks(4);
      ser_clk = 1'b0;
      wait_clks(3);
    end
  endtask

  task automatic load_pulse();
    ser_le = 1'b1;
    wait_clks(8);
    ser_le = 1'b0;
    wait_clks(6);
  endtask

  function automatic logic [21:0] ref_word(int ch, int ratio, int pol, int cur,
                                           int hiz, int ld, int fo);
    return {fo[0], ld[0], hiz[0], cur[0], pol[0], 15'(ratio), ch[0], 1'b0};
  endfunction

  function automatic logic [21:0] fb_word(int ch, int swal, int mn, int md, int pd);
    return {pd[0], md[0], 11'(mn), 7'(swal), ch[0], 1'b1};
  endfunction

  task automatic model_ref(int ch, int ratio, int pol, int cur, int hiz, int ld, int fo);
    e_ratio[ch] = ratio; e_pol[ch] = pol; e_cur[ch] = cur;
    e_hiz[ch] = hiz; e_ld[ch] = ld; e_fo[ch] = fo;
    if (ratio < 3) e_err = 1;
  endtask

  task automatic model_fb(int ch, int swal, int mn, int md, int pd);
    e_swal[ch] = (ch == 0) ? (swal & 15) : swal;
    e_main[ch] = mn; e_mod[ch] = md; e_pd[ch] = pd;
    if (mn < 3) e_err = 1;
  endtask

  task automatic write_ref(int ch, int ratio, int pol, int cur, int hiz, int ld, int fo);
    send_bits(32'(ref_word(ch, ratio, pol, cur, hiz, ld, fo)), 22);
    load_pulse();
    model_ref(ch, ratio, pol, cur, hiz, ld, fo);
  endtask

  task automatic write_fb(int ch, int swal, int mn, int md, int pd);
    send_bits(32'(fb_word(ch, swal, mn, md, pd)), 22);
    load_pulse();
    model_fb(ch, swal, mn, md, pd);
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    check_all("R1");
  endtask

  // R2, R4: reference latch layout and bit order
  task automatic t_ref();
    write_ref(1, 12345, 1, 0, 1, 0, 1);
    check_all("R4");
    write_ref(0, 16385, 0, 1, 0, 1, 0);   // ratio LSB and MSB set: bit order R2
    check_all("R2");
  endtask

  // R3, R5, R6: feedback latches, steering, narrow swallow width
  task automatic t_fb();
    write_fb(1, 100, 1500, 1, 0);
    check_all("R3");
    check_all("R5");
    write_fb(0, 127, 3, 0, 1);            // upper swallow bits dropped; main=3 legal
    check_all("R6");
  endtask

  // R8: no update without a strobe edge
  task automatic t_noload();
    send_bits(32'(ref_word(1, 777, 0, 1, 0, 1, 1)), 22);
    wait_clks(10);
    check_all("R8");                       // shifted, strobe low
    ser_le = 1'b1;
    wait_clks(8);                          // this loads the shifted ref word
    model_ref(1, 777, 0, 1, 0, 1, 1);
    check_all("R8");
    send_bits(32'(fb_word(0, 5, 700, 1, 0)), 22);
    wait_clks(10);
    check_all("R8");                       // strobe held high, no reload
    ser_le = 1'b0;
    wait_clks(6);
    load_pulse();
    model_fb(0, 5, 700, 1, 0);
    check_all("R8");
  endtask

  // R9: excess leading bits are discarded
  task automatic t_extra();
    send_bits(32'h1AB, 9);
    send_bits(32'(ref_word(0, 4242, 1, 1, 1, 0, 0)), 22);
    load_pulse();
    model_ref(0, 4242, 1, 1, 1, 0, 0);
    check_all("R9");
  endtask

  // R7: illegal ratios and sticky flag
  task automatic t_bad();
    chk("R7", "ratio_err before bad write", int'(ratio_err), 0);
    write_ref(0, 2, 0, 0, 0, 0, 0);
    check_all("R7");
    write_ref(0, 500, 1, 0, 0, 0, 0);
    check_all("R7");
    do_reset();
    check_all("R1");
    write_ref(1, 3, 0, 0, 0, 0, 0);
    check_all("R7");
    write_fb(1, 0, 1, 0, 0);
    check_all("R7");
  endtask

  initial begin
    model_clear();
    t_reset();
    t_ref();
    t_fb();
    t_noload();
    t_extra();
    t_bad();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule